// File: doc/BRIEF.md
# Level-Adaptive Writeback and Invalidate Router

This block sits inside the controller of a cache shared by one cluster of cores. It holds a small table saying which software thread is currently running on each core of the cluster. Producer writebacks and consumer invalidates name the partner thread at the other end of the communication. The block looks that thread up in the table and decides how far the operation has to reach.

If a writeback's consumer runs inside the cluster, the shared cluster cache is enough. Otherwise the data must also go out to the next level. If an invalidate's producer runs inside the cluster, only the private copy is dropped. Otherwise the cluster-cache copy is dropped too, so that the next read fetches fresh data from further out.

Writebacks and invalidates that name no partner, and the variants that force the far level, skip the lookup and always take the longest path. The block only produces a registered routing decision with level enables. It does not move any data.

Top module: `wb_level_router`

## Requirements
- R1: After reset every table entry is invalid, and outValid, outHit, privInvEn, l2En and l3En are all 0.
- R2: A map event (mapValid=1) writes mapTid into the entry selected by mapCore (0..NUM_CORES-1) and marks it valid. A later map to the same core replaces the previous thread ID.
- R3: An unmap event (unmapValid=1) marks the entry selected by unmapCore invalid, so that its ID no longer matches. When a map and an unmap name the same core in one cycle, the map wins.
- R4: For a consumer writeback (reqCmd=3) whose reqTid matches a valid entry, the response has outHit=1, l2En=1, l3En=0 and privInvEn=0.
- R5: For a consumer writeback (reqCmd=3) with no match, the response has outHit=0, l2En=1, l3En=1 and privInvEn=0.
- R6: For a producer invalidate (reqCmd=4) with a match, the response has outHit=1, privInvEn=1, l2En=0 and l3En=0.
- R7: For a producer invalidate (reqCmd=4) with no match, the response has outHit=0, privInvEn=1, l2En=1 and l3En=0.
- R8: A plain writeback (reqCmd=1) or a forced-far writeback (reqCmd=5) gives l2En=1, l3En=1, privInvEn=0 and outHit=0, whatever the table holds. A plain invalidate (reqCmd=2) or a forced-far invalidate (reqCmd=6) gives privInvEn=1, l2En=1, l3En=0 and outHit=0.
- R9: For reqCmd 1 to 6 the response appears exactly one cycle after the request, with outValid=1 and with reqAddr and reqCmd echoed on outAddr and outCmd. Codes 0 (idle) and 7 (reserved) produce outValid=0 with all enables 0.
- R10: An invalid entry never matches, including an entry whose stored ID equals the requested ID (for example thread ID 0 after reset).
- R11: A lookup uses the table as it stood before any map or unmap applied in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mapValid | input | 1 | Map a thread onto a core |
| mapCore | input | CORE_W | Core index for the map event |
| mapTid | input | TID_W | Thread ID placed on the core |
| unmapValid | input | 1 | Remove the thread from a core |
| unmapCore | input | CORE_W | Core index for the unmap event |
| reqCmd | input | 3 | Request command code |
| reqAddr | input | ADDR_W | Line address of the request |
| reqTid | input | TID_W | Partner thread ID |
| outValid | output | 1 | Routing decision valid |
| outAddr | output | ADDR_W | Echoed address |
| outCmd | output | 3 | Echoed command |
| outHit | output | 1 | Partner thread found in the cluster |
| privInvEn | output | 1 | Act on the private cache copy |
| l2En | output | 1 | Act on the cluster shared cache |
| l3En | output | 1 | Act on the next outer level |

## Verification
A corrupted or stale table entry shows up one cycle after the first partner-tagged request that names that thread. It appears as a flipped outHit, together with the wrong l3En for a writeback or the wrong l2En for an invalidate. A broken command decode shows on the very next response as a wrong enable pattern or a missing outValid. The bench therefore fills the table, probes hit and miss thread IDs with each command, and then changes the table with remaps, unmaps, map-versus-unmap collisions and same-cycle updates, observing each change through the next lookup.

// File: rtl/route_pkg.sv
package route_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE     = 3'd0,
    CMD_WB       = 3'd1,
    CMD_INV      = 3'd2,
    CMD_WB_CONS  = 3'd3,
    CMD_INV_PROD = 3'd4,
    CMD_WB_FAR   = 3'd5,
    CMD_INV_FAR  = 3'd6,
    CMD_RSVD     = 3'd7
  } routeCmd_e;

  // Strobes from control to datapath for one request
  typedef struct packed {
    logic fire;       // recognised command, produce a decision
    logic isWrite;    // writeback family (else invalidate family)
    logic useLookup;  // partner ID must be matched against the table
  } reqStrobe_t;
endpackage

// File: rtl/route_ctrl.sv
module route_ctrl
  import route_pkg::*;
#(
  parameter int NUM_CORES = 8,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 mapValid,
  input  logic [CORE_W-1:0]    mapCore,
  input  logic                 unmapValid,
  input  logic [CORE_W-1:0]    unmapCore,
  input  logic [2:0]           reqCmd,
  output logic [NUM_CORES-1:0] setEn,
  output logic [NUM_CORES-1:0] clrEn,
  output reqStrobe_t           reqStb
);
  routeCmd_e cmdDec;
  assign cmdDec = routeCmd_e'(reqCmd);

  // Per-core update strobes; a map overrides an unmap on the same core
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_upd
    assign setEn[c] = mapValid && (mapCore == CORE_W'(c));
    assign clrEn[c] = unmapValid && (unmapCore == CORE_W'(c)) && !setEn[c];
  end

  always_comb begin
    reqStb = '0;
    unique case (cmdDec)
      CMD_WB, CMD_WB_FAR: begin
        reqStb.fire = 1'b1; reqStb.isWrite = 1'b1;
      end
      CMD_INV, CMD_INV_FAR: begin
        reqStb.fire = 1'b1;
      end
      CMD_WB_CONS: begin
        reqStb.fire = 1'b1; reqStb.isWrite = 1'b1; reqStb.useLookup = 1'b1;
      end
      CMD_INV_PROD: begin
        reqStb.fire = 1'b1; reqStb.useLookup = 1'b1;
      end
      default: reqStb = '0;
    endcase
  end
endmodule

// File: rtl/route_datapath.sv
module route_datapath
  import route_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int TID_W     = 8,
  parameter int ADDR_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CORES-1:0] setEn,
  input  logic [NUM_CORES-1:0] clrEn,
  input  logic [TID_W-1:0]     mapTid,
  input  reqStrobe_t           reqStb,
  input  logic [2:0]           reqCmd,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [TID_W-1:0]     reqTid,
  output logic                 outValid,
  output logic [ADDR_W-1:0]    outAddr,
  output logic [2:0]           outCmd,
  output logic                 outHit,
  output logic                 privInvEn,
  output logic                 l2En,
  output logic                 l3En
);
  logic [TID_W-1:0]     entryTid [NUM_CORES];
  logic [NUM_CORES-1:0] entryVld;
  logic [NUM_CORES-1:0] matchVec;
  logic                 tblHit;
  logic                 localHit;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryVld[c] <= 1'b0;
        entryTid[c] <= '0;
      end else if (setEn[c]) begin
        entryVld[c] <= 1'b1;
        entryTid[c] <= mapTid;
      end else if (clrEn[c]) begin
        entryVld[c] <= 1'b0;
      end
    end
    // Fully parallel compare against the pre-update table contents
    assign matchVec[c] = entryVld[c] && (entryTid[c] == reqTid);
  end

  assign tblHit   = |matchVec;
  assign localHit = reqStb.useLookup && tblHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outAddr   <= '0;
      outCmd    <= '0;
      outHit    <= 1'b0;
      privInvEn <= 1'b0;
      l2En      <= 1'b0;
      l3En      <= 1'b0;
    end else begin
      outValid <= reqStb.fire;
      outAddr  <= reqAddr;
      outCmd   <= reqCmd;
      if (!reqStb.fire) begin
        outHit    <= 1'b0;
        privInvEn <= 1'b0;
        l2En      <= 1'b0;
        l3En      <= 1'b0;
      end else if (reqStb.isWrite) begin
        outHit    <= localHit;
        privInvEn <= 1'b0;
        l2En      <= 1'b1;
        l3En      <= !localHit;
      end else begin
        outHit    <= localHit;
        privInvEn <= 1'b1;
        l2En      <= !localHit;
        l3En      <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wb_level_router.sv
module wb_level_router
  import route_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int TID_W     = 8,
  parameter int ADDR_W    = 32,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mapValid,
  input  logic [CORE_W-1:0] mapCore,
  input  logic [TID_W-1:0]  mapTid,
  input  logic              unmapValid,
  input  logic [CORE_W-1:0] unmapCore,
  input  logic [2:0]        reqCmd,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [TID_W-1:0]  reqTid,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic [2:0]        outCmd,
  output logic              outHit,
  output logic              privInvEn,
  output logic              l2En,
  output logic              l3En
);
  logic [NUM_CORES-1:0] setEn;
  logic [NUM_CORES-1:0] clrEn;
  reqStrobe_t           reqStb;

  route_ctrl #(.NUM_CORES(NUM_CORES)) u_ctrl (
    .mapValid(mapValid), .mapCore(mapCore),
    .unmapValid(unmapValid), .unmapCore(unmapCore),
    .reqCmd(reqCmd), .setEn(setEn), .clrEn(clrEn), .reqStb(reqStb)
  );

  route_datapath #(.NUM_CORES(NUM_CORES), .TID_W(TID_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .setEn(setEn), .clrEn(clrEn), .mapTid(mapTid),
    .reqStb(reqStb), .reqCmd(reqCmd), .reqAddr(reqAddr), .reqTid(reqTid),
    .outValid(outValid), .outAddr(outAddr), .outCmd(outCmd), .outHit(outHit),
    .privInvEn(privInvEn), .l2En(l2En), .l3En(l3En)
  );
endmodule

// File: rtl/wb_level_router_chk.sv
module wb_level_router_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        reqCmd,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              outValid,
  input logic [ADDR_W-1:0] outAddr,
  input logic [2:0]        outCmd,
  input logic              outHit,
  input logic              privInvEn,
  input logic              l2En,
  input logic              l3En
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(outHit || privInvEn || l2En || l3En)); // R9
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (reqCmd != 3'd0 && reqCmd != 3'd7) |=> outValid && outCmd == $past(reqCmd)); // R9
  AST_ADDR_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    (reqCmd != 3'd0 && reqCmd != 3'd7) |=> outAddr == $past(reqAddr)); // R9
  AST_CONS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCmd == 3'd3 && outHit) |-> (l2En && !l3En && !privInvEn)); // R4
  AST_CONS_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCmd == 3'd3 && !outHit) |-> (l2En && l3En && !privInvEn)); // R5
  AST_PROD_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCmd == 3'd4 && outHit) |-> (privInvEn && !l2En && !l3En)); // R6
  AST_PROD_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCmd == 3'd4 && !outHit) |-> (privInvEn && l2En && !l3En)); // R7
  AST_PLAIN_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outCmd != 3'd3 && outCmd != 3'd4) |-> (!outHit && l2En)); // R8
endmodule

bind wb_level_router wb_level_router_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqCmd(reqCmd), .reqAddr(reqAddr),
  .outValid(outValid), .outAddr(outAddr), .outCmd(outCmd), .outHit(outHit),
  .privInvEn(privInvEn), .l2En(l2En), .l3En(l3En)
);

// File: tb/wb_level_router_test.sv
module wb_level_router_test;
  localparam int NUM_CORES = 8;
  localparam int TID_W = 8;
  localparam int ADDR_W = 32;
  localparam int CORE_W = 3;
  localparam int NVEC = 12;

  // vector: {cmd[3], tid[8], valid, hit, priv, l2, l3}
  localparam logic [15:0] VEC [NVEC] = '{
    {3'd3, 8'h42, 5'b11010},  // R4 consumer local
    {3'd3, 8'h43, 5'b10011},  // R5 consumer remote
    {3'd4, 8'h11, 5'b11100},  // R6 producer local
    {3'd4, 8'h12, 5'b10110},  // R7 producer remote
    {3'd1, 8'h42, 5'b10011},  // R8 plain wb ignores table
    {3'd5, 8'h42, 5'b10011},  // R8 forced far wb
    {3'd2, 8'h11, 5'b10110},  // R8 plain inv
    {3'd6, 8'h11, 5'b10110},  // R8 forced far inv
    {3'd0, 8'h42, 5'b00000},  // R9 idle
    {3'd7, 8'h42, 5'b00000},  // R9 reserved
    {3'd4, 8'hFF, 5'b11100},  // R6 last core
    {3'd3, 8'h00, 5'b10011}   // R10 invalid entries with tid 0
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mapValid = 1'b0, unmapValid = 1'b0;
  logic [CORE_W-1:0] mapCore = '0, unmapCore = '0;
  logic [TID_W-1:0] mapTid = '0, reqTid = '0;
  logic [2:0] reqCmd = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic outValid, outHit, privInvEn, l2En, l3En;
  logic [ADDR_W-1:0] outAddr;
  logic [2:0] outCmd;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  wb_level_router #(.NUM_CORES(NUM_CORES), .TID_W(TID_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .mapValid(mapValid), .mapCore(mapCore), .mapTid(mapTid),
    .unmapValid(unmapValid), .unmapCore(unmapCore), .reqCmd(reqCmd), .reqAddr(reqAddr),
    .reqTid(reqTid), .outValid(outValid), .outAddr(outAddr), .outCmd(outCmd),
    .outHit(outHit), .privInvEn(privInvEn), .l2En(l2En), .l3En(l3En)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {outValid, outHit, privInvEn, l2En, l3En};
  endfunction

  task automatic doMap(input logic [CORE_W-1:0] c, input logic [TID_W-1:0] t);
    @(negedge clk);
    mapValid = 1'b1; mapCore = c; mapTid = t;
    @(negedge clk);
    mapValid = 1'b0;
  endtask

  task automatic doReq(input logic [2:0] cmd, input logic [TID_W-1:0] t, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    reqCmd = cmd; reqTid = t; reqAddr = a;
    @(posedge clk); #1;
    reqCmd = 3'd0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 outputs after reset", {27'd0, outs()}, 32'd0);
    @(negedge clk); rstN = 1'b1;
    doReq(3'd3, 8'h00, 32'h0);
    check("R1 empty table misses", {27'd0, outs()}, {27'd0, 5'b10011});

    doMap(3'd0, 8'h11);
    doMap(3'd3, 8'h42);
    doMap(3'd7, 8'hFF);

    for (int i = 0; i < NVEC; i++) begin
      doReq(VEC[i][15:13], VEC[i][12:5], 32'h1000 + i);
      check($sformatf("R4-8 vector %0d", i), {27'd0, outs()}, {27'd0, VEC[i][4:0]});
    end

    doReq(3'd4, 8'h42, 32'hCAFE_0040);
    check("R9 addr echo", outAddr, 32'hCAFE_0040);
    check("R9 cmd echo", {29'd0, outCmd}, 32'd4);

    // R2 remap core 0
    doMap(3'd0, 8'h22);
    doReq(3'd3, 8'h11, 32'h0);
    check("R2 replaced id misses", {31'd0, outHit}, 32'd0);
    doReq(3'd3, 8'h22, 32'h0);
    check("R2 new id hits", {27'd0, outs()}, {27'd0, 5'b11010});

    // R3 unmap core 3
    @(negedge clk); unmapValid = 1'b1; unmapCore = 3'd3;
    @(negedge clk); unmapValid = 1'b0;
    doReq(3'd4, 8'h42, 32'h0);
    check("R3 unmapped misses", {27'd0, outs()}, {27'd0, 5'b10110});

    // R3 map wins over unmap on same core
    @(negedge clk); mapValid = 1'b1; mapCore = 3'd3; mapTid = 8'h42;
    unmapValid = 1'b1; unmapCore = 3'd3;
    @(negedge clk); mapValid = 1'b0; unmapValid = 1'b0;
    doReq(3'd3, 8'h42, 32'h0);
    check("R3 map beats unmap", {31'd0, outHit}, 32'd1);

    // R11 same-cycle map not seen by the lookup
    @(negedge clk); mapValid = 1'b1; mapCore = 3'd5; mapTid = 8'h55;
    reqCmd = 3'd3; reqTid = 8'h55;
    @(posedge clk); #1; mapValid = 1'b0; reqCmd = 3'd0;
    check("R11 same-cycle map unseen", {27'd0, outs()}, {27'd0, 5'b10011});
    doReq(3'd3, 8'h55, 32'h0);
    check("R11 map seen next cycle", {31'd0, outHit}, 32'd1);

    // R11 same-cycle unmap not seen
    @(negedge clk); unmapValid = 1'b1; unmapCore = 3'd5;
    reqCmd = 3'd4; reqTid = 8'h55;
    @(posedge clk); #1; unmapValid = 1'b0; reqCmd = 3'd0;
    check("R11 same-cycle unmap unseen", {31'd0, outHit}, 32'd1);
    doReq(3'd4, 8'h55, 32'h0);
    check("R3 R10 cleared entry misses", {31'd0, outHit}, 32'd0);

    // R9 no response the cycle after a single request
    @(posedge clk); #1;
    check("R9 single-cycle response", {31'd0, outValid}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule